// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves a processor's move-to and move-from special-purpose register operations. A register is named by a 16-bit address made of a 5-bit group number and an 11-bit index. The block holds a small set of system registers, a 64-bit multiply-accumulate register reachable as two 32-bit halves, an interrupt mask and pending-status pair, and a power-management register. Some registers do not simply overwrite on a write. Mask writes can only add bits, status writes clear the bits that are written as 1, and each accumulator half is written on its own. Some writes also send a one-cycle pulse to neighbouring logic.

Reads use a request/response port. The caller presents an address together with the value the destination register holds now. One cycle later the block returns either the mapped register's value or, for an address it does not implement, that previous destination value unchanged. Writes to read-only or unmapped addresses are dropped without any error indication.

Top module: `spr_unit`

## Requirements
- R1: The address is `{group[4:0], index[10:0]}`. Group 0 holds the system registers: version at index 0, configuration at 2, vector base at 11, status at 17, exception PC at 32, exception address at 48, exception status at 64, core id at 128 and core count at 129. The accumulator is in group 5, the power register in group 8, and the interrupt pair in group 9. An index that is mapped in one group but is used with a different group is treated as unmapped.
- R2: A write to the interrupt mask (group 9, index 0) ORs the written value into the mask. No mask bit can be cleared by a write.
- R3: A write to the interrupt status (group 9, index 2) clears each bit written as 1 and leaves bits written as 0 unchanged. Every cycle, each bit of `irq_in` that is high sets the matching status bit. If a bit is set and cleared in the same cycle, the set wins.
- R4: Group 5 index 1 reads and writes accumulator bits 31:0. Group 5 index 2 reads and writes bits 63:32. A write to one half leaves the other half unchanged.
- R5: A status-register write that changes bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) drives `flush_xlate` high for exactly the next cycle. A status write that changes none of these bits gives no pulse.
- R6: A power-register write (group 8, index 0) with bit 4 (doze) or bit 5 (sleep) set drives `halt_req` high for one cycle, together with `pc_advance` = 4. In all other cycles `pc_advance` is 0.
- R7: A read of an unmapped address returns `dest_prev` as it was sampled with the request.
- R8: Core id and core count read back `core_id_i` and `core_cnt_i`. Writes to these two registers and to the configuration register have no effect.
- R9: After reset every register is zero, except version (`VERSION_RESET`) and configuration (`CFG_RESET`). After reset `rvalid`, `rdata`, `flush_xlate` and `halt_req` are all 0.
- R10: `rvalid` is high exactly in the cycle after a read request, and `rdata` holds its value until the next read. A read and a write to the same register in the same cycle return the value from before the write.
- R11: Version, vector base, status, exception PC, exception address, exception status and power register each read back the last value written to them.
- R12: The mask and status registers are `IRQ_W` bits wide. Their upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| addr | input | 16 | Register address, group and index |
| wdata | input | 32 | Write data |
| dest_prev | input | 32 | Current value of the read's destination register |
| irq_in | input | IRQ_W | Interrupt sources, each setting one status bit |
| core_id_i | input | 32 | Identifier of this core |
| core_cnt_i | input | 32 | Number of cores in the system |
| rvalid | output | 1 | Read response valid |
| rdata | output | 32 | Read response data |
| flush_xlate | output | 1 | One-cycle address-translation flush pulse |
| halt_req | output | 1 | One-cycle halt request |
| pc_advance | output | 3 | PC step reported with a halt request (4), else 0 |

## Verification
The bench builds the unit with `IRQ_W` = 8. This makes the zero upper bits of the mask and status reads visible after all-ones writes. It also gives `VERSION_RESET` and `CFG_RESET` distinct non-zero values, so the reset readback cannot pass by chance. The core-id and core-count inputs are tied to distinct constants, so a swapped mapping shows up. A behavioural model is updated on every clock and compared with all outputs. The stimulus covers mapped indices used with the wrong group, same-cycle set and clear of a status bit, and a read and a write to the same register in one cycle.

// File: rtl/spr_pkg.sv
// Shared definitions for the special-purpose register unit.
// Assumes a 16-bit address: 5-bit group above an 11-bit index.
package spr_pkg;
    localparam int GRP_W = 5;
    localparam int IDX_W = 11;
    localparam int AW    = GRP_W + IDX_W;
    localparam int DW    = 32;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_VER, SEL_CFG, SEL_VEC, SEL_SR, SEL_EPC, SEL_EEA,
        SEL_ESR, SEL_COREID, SEL_NCORES, SEL_MACLO, SEL_MACHI, SEL_PMR,
        SEL_PICMR, SEL_PICSR
    } spr_sel_e;

    function automatic logic [AW-1:0] spr_make_addr(logic [GRP_W-1:0] g,
                                                    logic [IDX_W-1:0] i);
        return {g, i};
    endfunction

    localparam logic [AW-1:0] A_VER    = spr_make_addr(5'd0, 11'd0);
    localparam logic [AW-1:0] A_CFG    = spr_make_addr(5'd0, 11'd2);
    localparam logic [AW-1:0] A_VEC    = spr_make_addr(5'd0, 11'd11);
    localparam logic [AW-1:0] A_SR     = spr_make_addr(5'd0, 11'd17);
    localparam logic [AW-1:0] A_EPC    = spr_make_addr(5'd0, 11'd32);
    localparam logic [AW-1:0] A_EEA    = spr_make_addr(5'd0, 11'd48);
    localparam logic [AW-1:0] A_ESR    = spr_make_addr(5'd0, 11'd64);
    localparam logic [AW-1:0] A_COREID = spr_make_addr(5'd0, 11'd128);
    localparam logic [AW-1:0] A_NCORES = spr_make_addr(5'd0, 11'd129);
    localparam logic [AW-1:0] A_MACLO  = spr_make_addr(5'd5, 11'd1);
    localparam logic [AW-1:0] A_MACHI  = spr_make_addr(5'd5, 11'd2);
    localparam logic [AW-1:0] A_PMR    = spr_make_addr(5'd8, 11'd0);
    localparam logic [AW-1:0] A_PICMR  = spr_make_addr(5'd9, 11'd0);
    localparam logic [AW-1:0] A_PICSR  = spr_make_addr(5'd9, 11'd2);

    // Status bits whose change invalidates address translation.
    localparam logic [DW-1:0] SR_XLATE_MASK = 32'h0000_0061;
    // Power-register bits that request a halt (doze, sleep).
    localparam logic [DW-1:0] PM_HALT_MASK  = 32'h0000_0030;
    localparam logic [2:0]    PC_STEP       = 3'd4;

    // Plain read/write registers, kept together in one bank.
    localparam int N_PLAIN = 5;
    localparam int P_VER = 0, P_VEC = 1, P_EPC = 2, P_EEA = 3, P_ESR = 4;

    function automatic spr_sel_e plain_sel(int k);
        case (k)
            P_VER:   return SEL_VER;
            P_VEC:   return SEL_VEC;
            P_EPC:   return SEL_EPC;
            P_EEA:   return SEL_EEA;
            default: return SEL_ESR;
        endcase
    endfunction
endpackage

// File: rtl/spr_decode.sv
// Address decoder: maps a full group/index address to a register select.
// Assumes exact matching; any other address selects SEL_NONE.
module spr_decode
    import spr_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    output spr_sel_e      sel_o
);
    // Full-address compare against every implemented register.
    always_comb begin
        sel_o = SEL_NONE;
        case (addr_i)
            A_VER:    sel_o = SEL_VER;
            A_CFG:    sel_o = SEL_CFG;
            A_VEC:    sel_o = SEL_VEC;
            A_SR:     sel_o = SEL_SR;
            A_EPC:    sel_o = SEL_EPC;
            A_EEA:    sel_o = SEL_EEA;
            A_ESR:    sel_o = SEL_ESR;
            A_COREID: sel_o = SEL_COREID;
            A_NCORES: sel_o = SEL_NCORES;
            A_MACLO:  sel_o = SEL_MACLO;
            A_MACHI:  sel_o = SEL_MACHI;
            A_PMR:    sel_o = SEL_PMR;
            A_PICMR:  sel_o = SEL_PICMR;
            A_PICSR:  sel_o = SEL_PICSR;
            default:  sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/spr_sys_bank.sv
// System register bank: plain registers, the status register with its
// translation-flush pulse, and the power register with its halt request.
// Assumes a write is qualified by wr_en_i together with the decoded select.
module spr_sys_bank
    import spr_pkg::*;
#(
    parameter logic [DW-1:0] VERSION_RESET = 32'h0000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  spr_sel_e                    sel_i,
    input  logic [DW-1:0]               wdata_i,
    output logic [N_PLAIN-1:0][DW-1:0]  plain_o,
    output logic [DW-1:0]               sr_o,
    output logic [DW-1:0]               pm_o,
    output logic                        flush_o,
    output logic                        halt_o,
    output logic [2:0]                  pc_adv_o
);
    logic wr_sr, wr_pm;
    assign wr_sr = wr_en_i && (sel_i == SEL_SR);
    assign wr_pm = wr_en_i && (sel_i == SEL_PMR);

    // One generated register per plain read/write entry.
    for (genvar k = 0; k < N_PLAIN; k++) begin : g_plain
        localparam logic [DW-1:0] RST_V = (k == P_VER) ? VERSION_RESET : '0;
        // Capture write data when this entry is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                plain_o[k] <= RST_V;
            else if (wr_en_i && sel_i == plain_sel(k))
                plain_o[k] <= wdata_i;
        end
    end

    // Status register and flush pulse on a translation-relevant change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_o    <= '0;
            flush_o <= 1'b0;
        end else begin
            flush_o <= wr_sr && (|((sr_o ^ wdata_i) & SR_XLATE_MASK));
            if (wr_sr)
                sr_o <= wdata_i;
        end
    end

    // Power register and halt request on a doze or sleep write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_o   <= '0;
            halt_o <= 1'b0;
        end else begin
            halt_o <= wr_pm && (|(wdata_i & PM_HALT_MASK));
            if (wr_pm)
                pm_o <= wdata_i;
        end
    end

    // PC step reported alongside a halt.
    assign pc_adv_o = halt_o ? PC_STEP : 3'd0;

    // R5
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(wr_sr));
    // R6
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (|(pm_o & PM_HALT_MASK)));
endmodule

// File: rtl/spr_accum.sv
// 64-bit multiply-accumulate register written one 32-bit half at a time.
// Assumes at most one half is selected in a cycle.
module spr_accum
    import spr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [2*DW-1:0]   acc_o
);
    // Deposit the written half, keep the other.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_o <= '0;
        else if (wr_lo_i)
            acc_o[DW-1:0] <= wdata_i;
        else if (wr_hi_i)
            acc_o[2*DW-1:DW] <= wdata_i;
    end

    // R4
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_lo_i) |-> acc_o[2*DW-1:DW] == $past(acc_o[2*DW-1:DW]));
    // R4
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hi_i) |-> acc_o[DW-1:0] == $past(acc_o[DW-1:0]));
endmodule

// File: rtl/spr_irq_regs.sv
// Interrupt mask (OR-set on write) and pending status (write-1-to-clear,
// set by interrupt sources, set dominates a same-cycle clear).
module spr_irq_regs #(
    parameter int IRQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask_i,
    input  logic             wr_stat_i,
    input  logic [IRQ_W-1:0] wdata_i,
    input  logic [IRQ_W-1:0] irq_i,
    output logic [IRQ_W-1:0] mask_o,
    output logic [IRQ_W-1:0] stat_o
);
    // Mask only accumulates bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_mask_i)
            mask_o <= mask_o | wdata_i;
    end

    // Status: clear written ones, then apply sources.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_o <= '0;
        else
            stat_o <= (stat_o & ~(wr_stat_i ? wdata_i : '0)) | irq_i;
    end

    // R2
    mask_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mask_o & $past(mask_o)) == $past(mask_o));
    // R3
    stat_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_o & ~$past(stat_o) & ~$past(irq_i)) == '0);
    // R3
    stat_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_o & $past(irq_i)) == $past(irq_i));
endmodule

// File: rtl/spr_unit.sv
// Special-purpose register access unit: decodes move-to/move-from
// operations, applies per-register write rules and answers reads one
// cycle later, passing the old destination value for unmapped addresses.
module spr_unit
    import spr_pkg::*;
#(
    parameter int              IRQ_W         = 32,
    parameter logic [DW-1:0]   VERSION_RESET = 32'h0001_0000,
    parameter logic [DW-1:0]   CFG_RESET     = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_req,
    input  logic [15:0]      addr,
    input  logic [31:0]      wdata,
    input  logic [31:0]      dest_prev,
    input  logic [IRQ_W-1:0] irq_in,
    input  logic [31:0]      core_id_i,
    input  logic [31:0]      core_cnt_i,
    output logic             rvalid,
    output logic [31:0]      rdata,
    output logic             flush_xlate,
    output logic             halt_req,
    output logic [2:0]       pc_advance
);
    spr_sel_e                   sel;
    logic [N_PLAIN-1:0][DW-1:0] plain;
    logic [DW-1:0]              sr_q, pm_q, rmux;
    logic [2*DW-1:0]            acc;
    logic [IRQ_W-1:0]           mask_q, stat_q;

    spr_decode u_dec (.addr_i(addr), .sel_o(sel));

    spr_sys_bank #(.VERSION_RESET(VERSION_RESET)) u_sys (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_req), .sel_i(sel),
        .wdata_i(wdata), .plain_o(plain), .sr_o(sr_q), .pm_o(pm_q),
        .flush_o(flush_xlate), .halt_o(halt_req), .pc_adv_o(pc_advance)
    );

    spr_accum u_acc (
        .clk(clk), .rst_n(rst_n),
        .wr_lo_i(wr_req && sel == SEL_MACLO),
        .wr_hi_i(wr_req && sel == SEL_MACHI),
        .wdata_i(wdata), .acc_o(acc)
    );

    spr_irq_regs #(.IRQ_W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_mask_i(wr_req && sel == SEL_PICMR),
        .wr_stat_i(wr_req && sel == SEL_PICSR),
        .wdata_i(wdata[IRQ_W-1:0]), .irq_i(irq_in),
        .mask_o(mask_q), .stat_o(stat_q)
    );

    // Select the read value; unmapped addresses echo the old destination.
    always_comb begin
        case (sel)
            SEL_VER:    rmux = plain[P_VER];
            SEL_CFG:    rmux = CFG_RESET;
            SEL_VEC:    rmux = plain[P_VEC];
            SEL_SR:     rmux = sr_q;
            SEL_EPC:    rmux = plain[P_EPC];
            SEL_EEA:    rmux = plain[P_EEA];
            SEL_ESR:    rmux = plain[P_ESR];
            SEL_COREID: rmux = core_id_i;
            SEL_NCORES: rmux = core_cnt_i;
            SEL_MACLO:  rmux = acc[DW-1:0];
            SEL_MACHI:  rmux = acc[2*DW-1:DW];
            SEL_PMR:    rmux = pm_q;
            SEL_PICMR:  rmux = DW'(mask_q);
            SEL_PICSR:  rmux = DW'(stat_q);
            default:    rmux = dest_prev;
        endcase
    end

    // Register the read response for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= rmux;
        end
    end

    // R10
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_req));
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_req)) |-> $stable(rdata));
    // R7
    unmapped_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(sel) == SEL_NONE) |-> rdata == $past(dest_prev));
endmodule

// File: tb/spr_unit_tb.sv
module spr_unit_tb;
    localparam int          IRQ_W = 8;
    localparam logic [31:0] VER_R = 32'h0012_0034;
    localparam logic [31:0] CFG_R = 32'h0000_0A5C;
    localparam logic [31:0] CID   = 32'h0000_0003;
    localparam logic [31:0] CCNT  = 32'h0000_0004;

    function automatic logic [15:0] ad(int g, int i);
        return {g[4:0], i[10:0]};
    endfunction

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_req = 1'b0, rd_req = 1'b0;
    logic [15:0]      addr = '0;
    logic [31:0]      wdata = '0, dest_prev = '0;
    logic [IRQ_W-1:0] irq_in = '0;
    logic             rvalid, flush_xlate, halt_req;
    logic [31:0]      rdata;
    logic [2:0]       pc_advance;

    spr_unit #(.IRQ_W(IRQ_W), .VERSION_RESET(VER_R), .CFG_RESET(CFG_R)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .addr(addr), .wdata(wdata), .dest_prev(dest_prev), .irq_in(irq_in),
        .core_id_i(CID), .core_cnt_i(CCNT), .rvalid(rvalid), .rdata(rdata),
        .flush_xlate(flush_xlate), .halt_req(halt_req), .pc_advance(pc_advance)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model state
    logic [31:0] m_ver, m_vec, m_sr, m_epc, m_eea, m_esr, m_pm;
    logic [63:0] m_mac;
    logic [31:0] m_mask, m_stat;
    logic        e_valid, e_flush, e_halt;
    logic [31:0] e_data;
    string       e_tag = "R9";
    bit          started = 0;

    function automatic string req_of(logic [15:0] a);
        if (a == ad(0,0) || a == ad(0,2)) return "R9";
        if (a == ad(0,128) || a == ad(0,129)) return "R8";
        if (a == ad(5,1) || a == ad(5,2)) return "R4";
        if (a == ad(9,0)) return "R2";
        if (a == ad(9,2)) return "R3";
        if (a == ad(0,11) || a == ad(0,17) || a == ad(0,32) || a == ad(0,48) ||
            a == ad(0,64) || a == ad(8,0)) return "R11";
        if (a[10:0] == 11'd17 || a[10:0] == 11'd0) return "R1";
        return "R7";
    endfunction

    function automatic logic [31:0] m_read(logic [15:0] a, logic [31:0] old);
        if (a == ad(0,0))   return m_ver;
        if (a == ad(0,2))   return CFG_R;
        if (a == ad(0,11))  return m_vec;
        if (a == ad(0,17))  return m_sr;
        if (a == ad(0,32))  return m_epc;
        if (a == ad(0,48))  return m_eea;
        if (a == ad(0,64))  return m_esr;
        if (a == ad(0,128)) return CID;
        if (a == ad(0,129)) return CCNT;
        if (a == ad(5,1))   return m_mac[31:0];
        if (a == ad(5,2))   return m_mac[63:32];
        if (a == ad(8,0))   return m_pm;
        if (a == ad(9,0))   return m_mask;
        if (a == ad(9,2))   return m_stat;
        return old;
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_ver = VER_R; m_vec = 0; m_sr = 0; m_epc = 0; m_eea = 0;
            m_esr = 0; m_pm = 0; m_mac = 0; m_mask = 0; m_stat = 0;
            e_valid = 0; e_data = 0; e_flush = 0; e_halt = 0; e_tag = "R9";
        end else begin
            logic [31:0] clr;
            e_valid = rd_req;
            if (rd_req) begin
                e_data = m_read(addr, dest_prev);
                e_tag  = req_of(addr);
            end
            e_flush = wr_req && addr == ad(0,17) && (((m_sr ^ wdata) & 32'h61) != 0);
            e_halt  = wr_req && addr == ad(8,0) && (wdata[4] || wdata[5]);
            clr = (wr_req && addr == ad(9,2)) ? wdata : 32'h0;
            if (wr_req) begin
                if (addr == ad(0,0))  m_ver = wdata;
                if (addr == ad(0,11)) m_vec = wdata;
                if (addr == ad(0,17)) m_sr  = wdata;
                if (addr == ad(0,32)) m_epc = wdata;
                if (addr == ad(0,48)) m_eea = wdata;
                if (addr == ad(0,64)) m_esr = wdata;
                if (addr == ad(8,0))  m_pm  = wdata;
                if (addr == ad(5,1))  m_mac[31:0]  = wdata;
                if (addr == ad(5,2))  m_mac[63:32] = wdata;
                if (addr == ad(9,0))  m_mask = (m_mask | wdata) & 32'hFF;
            end
            m_stat = ((m_stat & ~clr) | 32'(irq_in)) & 32'hFF;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            cmp("R10 rvalid", 32'(rvalid), 32'(e_valid));
            cmp({e_tag, " rdata"}, rdata, e_data);
            cmp("R5 flush_xlate", 32'(flush_xlate), 32'(e_flush));
            cmp("R6 halt_req", 32'(halt_req), 32'(e_halt));
            cmp("R6 pc_advance", 32'(pc_advance), e_halt ? 32'd4 : 32'd0);
        end
    end

    task automatic op(bit w, bit r, logic [15:0] a, logic [31:0] d,
                      logic [31:0] old, logic [IRQ_W-1:0] irq);
        @(negedge clk);
        wr_req = w; rd_req = r; addr = a; wdata = d; dest_prev = old; irq_in = irq;
        @(posedge clk);
        #1;
        wr_req = 0; rd_req = 0; irq_in = '0;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        op(1, 0, a, d, 32'h0, '0);
    endtask

    task automatic rd(logic [15:0] a, logic [31:0] old);
        op(0, 1, a, 32'h0, old, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: outputs idle straight after reset
        cmp("R9 rvalid reset", 32'(rvalid), 32'h0);
        cmp("R9 rdata reset", rdata, 32'h0);
        cmp("R9 flush reset", 32'(flush_xlate), 32'h0);
        @(negedge clk);
        rst_n = 1;
        // R9: reset values
        rd(ad(0,0), 32'h1111_1111);
        cmp("R9 version reset", rdata, VER_R);
        rd(ad(0,2), 32'h1111_1111);
        cmp("R9 config reset", rdata, CFG_R);
        rd(ad(0,17), 32'hFFFF_FFFF);
        rd(ad(5,2), 32'hFFFF_FFFF);
        rd(ad(9,0), 32'hFFFF_FFFF);
        // R11: plain registers
        wr(ad(0,0), 32'hA0A0_0001);  wr(ad(0,11), 32'h0000_2000);
        wr(ad(0,32), 32'h1234_5678); wr(ad(0,48), 32'h8765_4321);
        wr(ad(0,64), 32'h0000_00C3); wr(ad(8,0), 32'h0000_0001);
        wr(ad(0,17), 32'h0000_0002);
        rd(ad(0,0), 0); rd(ad(0,11), 0); rd(ad(0,32), 0); rd(ad(0,48), 0);
        rd(ad(0,64), 0); rd(ad(8,0), 0); rd(ad(0,17), 0);
        // R5: flush on translation-bit changes only
        wr(ad(0,17), 32'h0000_0022);
        cmp("R5 flush after data-xlate change", 32'(flush_xlate), 32'h1);
        wr(ad(0,17), 32'h0000_0023 & 32'hFFFF_FFFE | 32'h8);
        wr(ad(0,17), 32'h0000_002B);
        wr(ad(0,17), 32'h0000_006B);
        wr(ad(0,17), 32'h0000_006B);
        cmp("R5 no flush on equal write", 32'(flush_xlate), 32'h0);
        // R6: halt requests
        wr(ad(8,0), 32'h0000_0010);
        cmp("R6 pc_advance doze", 32'(pc_advance), 32'd4);
        wr(ad(8,0), 32'h0000_0020);
        wr(ad(8,0), 32'h0000_000F);
        cmp("R6 no halt", 32'(halt_req), 32'h0);
        // R4: accumulator halves
        wr(ad(5,1), 32'hCAFE_0001); wr(ad(5,2), 32'hBEEF_0002);
        wr(ad(5,1), 32'h0000_0003);
        rd(ad(5,1), 0);
        rd(ad(5,2), 0);
        cmp("R4 high half kept", rdata, 32'hBEEF_0002);
        // R2 / R12: mask OR-set and width
        wr(ad(9,0), 32'h0000_000F); wr(ad(9,0), 32'h0000_00F0);
        wr(ad(9,0), 32'h0);
        rd(ad(9,0), 0);
        cmp("R2 mask accumulates", rdata, 32'h0000_00FF);
        wr(ad(9,0), 32'hFFFF_FFFF);
        rd(ad(9,0), 0);
        cmp("R12 mask upper bits", {8'h0, rdata[31:8]}, 32'h0);
        // R3: status set, clear, set-wins
        op(0, 0, ad(0,0), 0, 0, 8'h5A);
        rd(ad(9,2), 0);
        wr(ad(9,2), 32'h0000_000A);
        rd(ad(9,2), 0);
        cmp("R3 w1c", rdata, 32'h0000_0050);
        op(1, 0, ad(9,2), 32'h0000_0050, 0, 8'h40);
        rd(ad(9,2), 0);
        cmp("R3 set wins", rdata, 32'h0000_0040);
        wr(ad(9,2), 32'hFFFF_FFFF);
        rd(ad(9,2), 0);
        cmp("R12 status upper bits", rdata, 32'h0);
        // R7 / R1: unmapped echoes old destination
        rd(ad(3,0), 32'hDEAD_BEEF);
        cmp("R7 unmapped echo", rdata, 32'hDEAD_BEEF);
        rd(ad(1,17), 32'h0BAD_F00D);
        cmp("R1 wrong group", rdata, 32'h0BAD_F00D);
        rd(ad(9,1), 32'h7777_0000);
        wr(ad(4,11), 32'h5555_5555);
        rd(ad(0,11), 0);
        // R8: read-only registers
        wr(ad(0,128), 32'hFFFF_0000); wr(ad(0,129), 32'hFFFF_0000);
        wr(ad(0,2), 32'hFFFF_0000);
        rd(ad(0,128), 0);
        cmp("R8 core id", rdata, CID);
        rd(ad(0,129), 0);
        rd(ad(0,2), 0);
        cmp("R8 config ignored write", rdata, CFG_R);
        // R10: read with write in the same cycle, then idle hold
        op(1, 1, ad(0,11), 32'h0000_4000, 0, '0);
        cmp("R10 pre-write value", rdata, 32'h0000_2000);
        rd(ad(0,11), 0);
        repeat (3) @(negedge clk);
        cmp("R10 rvalid idle", 32'(rvalid), 32'h0);
        cmp("R10 rdata held", rdata, 32'h0000_4000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule